// File: doc/BRIEF.md
# DLL Phase Window Trainer

This block is a training controller for a delay-locked loop whose positive and negative sampling phases are set by 6-bit codes. It proposes code pairs to an external tester over a small handshake. Each proposal is either a trial, which the tester applies and then answers with pass or fail, or an apply-only request, which the tester simply installs. From these answers the block finds the passing window and settles on its centre.

Training begins with one full sweep in which both codes carry the same value. The centre of the passing values found there becomes the shared median. Six refinement rounds follow. Each one searches outward from the median, first upward and then downward. Odd rounds move the positive code and even rounds move the negative code. The centre of each round is installed before the next round starts. If a round finds nothing, the block restores the codes it was given at the start and reports failure. The one exception is the designated keep round, which ends training and leaves the current codes in place.

A training run is started with a one-cycle request that carries the original codes. The run ends with a one-cycle completion pulse that carries the final codes and a status bit.

Top module: `dll_phase_trainer`

## Requirements
- R1: After reset the block is idle: `train_done` and `trial_start` are low, and nothing happens until `train_go` is seen.
- R2: Round 0 issues exactly 64 trials with `trial_pos` equal to `trial_neg`, taking the values 0, 1, 2 … 63 in that order. Every result is used, whether it passes or fails.
- R3: In round 0 the lower bound is the first passing code and the upper bound is the last passing code. A round's centre is ((upper − lower) >> 1) + lower.
- R4: Rounds 1 to 6 start at the median and step up by 1 while trials pass, recording each pass as the upper bound. They then restart at the median and step down by 1 while trials pass, recording the lower bound. The downward walk stops at the first fail or after code 0.
- R5: In rounds 1, 3 and 5 the positive code moves while the negative code stays at the median. In rounds 2, 4 and 6 the negative code moves while the positive code holds the centre of the previous odd round.
- R6: After each successful round, one apply-only request (`trial_check`=0) installs the centre. Round 0 installs (c, c), odd rounds install (c, median) and even rounds install (previous odd centre, c).
- R7: Both bounds start each round at the all-ones sentinel, which is 7 bits wide and cannot be a valid code. A round fails if either bound is still the sentinel when its search ends.
- R8: A failure in rounds 0, 1, 2, 3, 5 or 6 causes one apply-only request with the original codes, followed by `train_done` with `train_ok`=0 and the final codes equal to the original codes.
- R9: A failure in round 4 ends training at once, with no restore request. It reports `train_ok`=1 and the codes of the last trial.
- R10: When round 6 succeeds, the block reports `train_ok`=1 with the final positive code equal to the round 5 centre and the final negative code equal to the round 6 centre.
- R11: An upward walk never proposes a code above 63, even when every trial passes.
- R12: `trial_start` and `train_done` are single-cycle pulses. `trial_pos` and `trial_neg` hold steady while a trial waits for `trial_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_go | input | 1 | One-cycle request to start training |
| init_pos | input | 6 | Original positive code, captured with `train_go` |
| init_neg | input | 6 | Original negative code, captured with `train_go` |
| trial_start | output | 1 | One-cycle pulse that starts a trial or an apply-only request |
| trial_check | output | 1 | 1 = run a trial and report pass or fail; 0 = install the codes only |
| trial_pos | output | 6 | Proposed positive code |
| trial_neg | output | 6 | Proposed negative code |
| trial_done | input | 1 | The tester has finished the current request |
| trial_pass | input | 1 | Trial result, valid together with `trial_done` |
| train_done | output | 1 | One-cycle pulse when training ends |
| train_ok | output | 1 | Final status, valid with `train_done` |
| final_pos | output | 6 | Final positive code, valid with `train_done` |
| final_neg | output | 6 | Final negative code, valid with `train_done` |

## Verification
The tester model answers from rectangular pass windows, and some of them carry a single failing hole. One window lies inside the range, one passes everywhere, one passes nowhere, and two touch code 0 or code 63. Together they separate the first-pass and last-pass bound rules, the stop at 63 and at 0, and the sentinel failure. A separate kill setting forces every trial from a chosen round onward to fail. This tells the restore rounds apart from the keep round. It also shows which code each round moves and what each apply-only request installs, because the bench predicts the full sequence of requests from the same window.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_ISSUE,
      ST_WAIT,
      ST_CENTER,
      ST_AP_ISSUE,
      ST_AP_WAIT,
      ST_FINISH
   } dpt_state_e;

   typedef enum logic {
      DIR_UP,
      DIR_DN
   } dpt_dir_e;

endpackage

// File: rtl/dpt_bounds.sv
module dpt_bounds #(
   parameter int PW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd_lo,
   input  logic          upd_lo_first,
   input  logic          upd_hi,
   input  logic [PW-1:0] code,
   output logic          found,
   output logic [PW-1:0] center
);
   localparam int            BW   = PW + 1;
   localparam logic [BW-1:0] SENT = '1;

   logic [BW-1:0] lo_q, hi_q, span, mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= SENT;
         hi_q <= SENT;
      end else if (clr) begin
         lo_q <= SENT;
         hi_q <= SENT;
      end else begin
         if (upd_lo || (upd_lo_first && lo_q == SENT)) lo_q <= {1'b0, code};
         if (upd_hi)                                   hi_q <= {1'b0, code};
      end
   end

   always_comb begin
      found  = (lo_q != SENT) && (hi_q != SENT);
      span   = hi_q - lo_q;
      mid    = (span >> 1) + lo_q;
      center = mid[PW-1:0];
   end

   // R3
   bounds_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> lo_q <= hi_q);

   // R3
   center_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ({1'b0, center} >= lo_q) && ({1'b0, center} <= hi_q));

   // R7
   clear_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !found);

endmodule

// File: rtl/dpt_codemap.sv
module dpt_codemap #(
   parameter int PW           = 6,
   parameter int RW           = 3,
   parameter bit VARY_POS_ODD = 1'b1
) (
   input  logic [RW-1:0] round,
   input  logic [PW-1:0] code,
   input  logic [PW-1:0] med,
   input  logic [PW-1:0] prev,
   output logic [PW-1:0] pos,
   output logic [PW-1:0] neg
);
   generate
      if (VARY_POS_ODD) begin : g_pos_odd
         always_comb begin
            if (round == '0) begin
               pos = code;
               neg = code;
            end else if (round[0]) begin
               pos = code;
               neg = med;
            end else begin
               pos = prev;
               neg = code;
            end
         end
      end else begin : g_neg_odd
         always_comb begin
            if (round == '0) begin
               pos = code;
               neg = code;
            end else if (round[0]) begin
               pos = med;
               neg = code;
            end else begin
               pos = code;
               neg = prev;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dll_phase_trainer.sv
module dll_phase_trainer import dpt_pkg::*; #(
   parameter int PW           = 6,
   parameter int LAST_ROUND   = 6,
   parameter int KEEP_ROUND   = 4,
   parameter bit VARY_POS_ODD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          train_go,
   input  logic [PW-1:0] init_pos,
   input  logic [PW-1:0] init_neg,
   output logic          trial_start,
   output logic          trial_check,
   output logic [PW-1:0] trial_pos,
   output logic [PW-1:0] trial_neg,
   input  logic          trial_done,
   input  logic          trial_pass,
   output logic          train_done,
   output logic          train_ok,
   output logic [PW-1:0] final_pos,
   output logic [PW-1:0] final_neg
);
   localparam int            RW    = $clog2(LAST_ROUND + 1);
   localparam logic [PW-1:0] MAXC  = '1;
   localparam logic [RW-1:0] LASTR = RW'(LAST_ROUND);
   localparam logic [RW-1:0] KEEPR = RW'(KEEP_ROUND);

   initial begin
      prm_width_chk: assert (PW >= 2) else $error("PW must be at least 2");
      prm_rounds_chk: assert (LAST_ROUND >= 1) else $error("need a refinement round");
      prm_keep_chk: assert (KEEP_ROUND <= LAST_ROUND) else $error("keep round out of range");
   end

   dpt_state_e    st;
   dpt_dir_e      dir_q;
   logic [RW-1:0] round_q;
   logic [PW-1:0] var_q, med_q, prev_q;
   logic [PW-1:0] orig_pos_q, orig_neg_q, app_pos_q, app_neg_q;
   logic [PW-1:0] last_pos_q, last_neg_q, fin_pos_q, fin_neg_q;
   logic          fin_ok_q, restore_q;

   logic [PW-1:0] map_code, map_pos, map_neg, ctr;
   logic          found, r0, at_top, at_bot, wait_ev, in_trial;
   logic          upd_lo, upd_lo_first, upd_hi;

   always_comb begin
      r0           = (round_q == '0);
      at_top       = (var_q == MAXC);
      at_bot       = (var_q == '0);
      wait_ev      = (st == ST_WAIT) && trial_done;
      in_trial     = (st == ST_ISSUE) || (st == ST_WAIT);
      map_code     = (st == ST_CENTER) ? ctr : var_q;
      upd_hi       = wait_ev && trial_pass && (r0 || dir_q == DIR_UP);
      upd_lo_first = wait_ev && trial_pass && r0;
      upd_lo       = wait_ev && trial_pass && !r0 && (dir_q == DIR_DN);
   end

   dpt_bounds #(.PW(PW)) u_bounds (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (st == ST_PREP),
      .upd_lo       (upd_lo),
      .upd_lo_first (upd_lo_first),
      .upd_hi       (upd_hi),
      .code         (var_q),
      .found        (found),
      .center       (ctr)
   );

   dpt_codemap #(.PW(PW), .RW(RW), .VARY_POS_ODD(VARY_POS_ODD)) u_map (
      .round (round_q),
      .code  (map_code),
      .med   (med_q),
      .prev  (prev_q),
      .pos   (map_pos),
      .neg   (map_neg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         dir_q      <= DIR_UP;
         round_q    <= '0;
         var_q      <= '0;
         med_q      <= '0;
         prev_q     <= '0;
         orig_pos_q <= '0;
         orig_neg_q <= '0;
         app_pos_q  <= '0;
         app_neg_q  <= '0;
         last_pos_q <= '0;
         last_neg_q <= '0;
         fin_pos_q  <= '0;
         fin_neg_q  <= '0;
         fin_ok_q   <= 1'b0;
         restore_q  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (train_go) begin
                  orig_pos_q <= init_pos;
                  orig_neg_q <= init_neg;
                  round_q    <= '0;
                  restore_q  <= 1'b0;
                  st         <= ST_PREP;
               end
            end
            ST_PREP: begin
               var_q <= r0 ? '0 : med_q;
               dir_q <= DIR_UP;
               st    <= ST_ISSUE;
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (trial_done) begin
                  last_pos_q <= map_pos;
                  last_neg_q <= map_neg;
                  if (r0) begin
                     if (at_top) st <= ST_CENTER;
                     else begin
                        var_q <= var_q + 1'b1;
                        st    <= ST_ISSUE;
                     end
                  end else if (dir_q == DIR_UP) begin
                     if (trial_pass && !at_top) begin
                        var_q <= var_q + 1'b1;
                     end else begin
                        dir_q <= DIR_DN;
                        var_q <= med_q;
                     end
                     st <= ST_ISSUE;
                  end else begin
                     if (trial_pass && !at_bot) begin
                        var_q <= var_q - 1'b1;
                        st    <= ST_ISSUE;
                     end else begin
                        st <= ST_CENTER;
                     end
                  end
               end
            end
            ST_CENTER: begin
               if (!found) begin
                  if (round_q == KEEPR) begin
                     fin_pos_q <= last_pos_q;
                     fin_neg_q <= last_neg_q;
                     fin_ok_q  <= 1'b1;
                     st        <= ST_FINISH;
                  end else begin
                     app_pos_q <= orig_pos_q;
                     app_neg_q <= orig_neg_q;
                     restore_q <= 1'b1;
                     st        <= ST_AP_ISSUE;
                  end
               end else begin
                  app_pos_q <= map_pos;
                  app_neg_q <= map_neg;
                  if (r0) med_q <= ctr;
                  if (r0 || round_q[0]) prev_q <= ctr;
                  st <= ST_AP_ISSUE;
               end
            end
            ST_AP_ISSUE: st <= ST_AP_WAIT;
            ST_AP_WAIT: begin
               if (trial_done) begin
                  last_pos_q <= app_pos_q;
                  last_neg_q <= app_neg_q;
                  if (restore_q) begin
                     fin_pos_q <= orig_pos_q;
                     fin_neg_q <= orig_neg_q;
                     fin_ok_q  <= 1'b0;
                     st        <= ST_FINISH;
                  end else if (round_q == LASTR) begin
                     fin_pos_q <= app_pos_q;
                     fin_neg_q <= app_neg_q;
                     fin_ok_q  <= 1'b1;
                     st        <= ST_FINISH;
                  end else begin
                     round_q <= round_q + 1'b1;
                     st      <= ST_PREP;
                  end
               end
            end
            ST_FINISH: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      trial_start = (st == ST_ISSUE) || (st == ST_AP_ISSUE);
      trial_check = in_trial;
      trial_pos   = in_trial ? map_pos : app_pos_q;
      trial_neg   = in_trial ? map_neg : app_neg_q;
      train_done  = (st == ST_FINISH);
      train_ok    = fin_ok_q;
      final_pos   = fin_pos_q;
      final_neg   = fin_neg_q;
   end

   // R12
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trial_start |=> !trial_start);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      train_done |=> !train_done);

   // R12
   codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !trial_done) |=> $stable(trial_pos) && $stable(trial_neg));

   // R2
   sweep_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trial_start && trial_check && r0) |-> trial_pos == trial_neg);

   // R11
   up_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_ev && !r0 && dir_q == DIR_UP && at_top) |=> dir_q == DIR_DN);

   // R11
   sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_ev && r0 && at_top) |=> st == ST_CENTER);

   // R8
   restore_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (train_done && !train_ok) |-> (final_pos == orig_pos_q) && (final_neg == orig_neg_q));

   // R9
   keep_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CENTER && !found && round_q == KEEPR) |=> train_done && train_ok);

endmodule

// File: tb/sim_dll_phase_trainer.sv
`timescale 1ns/1ps
module sim_dll_phase_trainer;
   localparam int S = 127;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       train_go = 1'b0;
   logic [5:0] init_pos = '0, init_neg = '0;
   logic       trial_start, trial_check, train_done, train_ok;
   logic [5:0] trial_pos, trial_neg, final_pos, final_neg;
   logic       trial_done = 1'b0, trial_pass = 1'b0;

   always #2.5 clk = ~clk;

   dll_phase_trainer u0 (
      .clk(clk), .rst_n(rst_n), .train_go(train_go),
      .init_pos(init_pos), .init_neg(init_neg),
      .trial_start(trial_start), .trial_check(trial_check),
      .trial_pos(trial_pos), .trial_neg(trial_neg),
      .trial_done(trial_done), .trial_pass(trial_pass),
      .train_done(train_done), .train_ok(train_ok),
      .final_pos(final_pos), .final_neg(final_neg)
   );

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   int plo, phi, nlo, nhi, hole, kill;
   int exp_pos, exp_neg, exp_ok, exp_trials, exp_applies;
   int exp_ap_pos[8], exp_ap_neg[8], exp_fixed[8];
   int got_ap_pos[8], got_ap_neg[8];
   int n_trials, n_applies, max_seen, r0_idx, r0_err, fix_err, done_hi, lat;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit pass_fn(input int p, input int n, input int r);
      return (r < kill) && p >= plo && p <= phi && n >= nlo && n <= nhi && p != hole && n != hole;
   endfunction

   task automatic ref_run(input int opos, input int oneg);
      int mn, mx, v, c, med, prev, lp, ln, p, n;
      exp_trials = 0; exp_applies = 0; med = 0; prev = 0; lp = 0; ln = 0;
      for (int r = 0; r <= 6; r++) begin
         mn = S; mx = S;
         exp_fixed[r] = r[0] ? med : prev;
         if (r == 0) begin
            for (int k = 0; k < 64; k++) begin
               exp_trials++; lp = k; ln = k;
               if (pass_fn(k, k, 0)) begin
                  if (mn == S) mn = k;
                  mx = k;
               end
            end
         end else begin
            v = med;
            while (1) begin
               if (r[0]) begin p = v; n = med; end else begin p = prev; n = v; end
               exp_trials++; lp = p; ln = n;
               if (!pass_fn(p, n, r)) break;
               mx = v;
               if (v == 63) break;
               v++;
            end
            v = med;
            while (1) begin
               if (r[0]) begin p = v; n = med; end else begin p = prev; n = v; end
               exp_trials++; lp = p; ln = n;
               if (!pass_fn(p, n, r)) break;
               mn = v;
               if (v == 0) break;
               v--;
            end
         end
         if (mn == S || mx == S) begin
            if (r == 4) begin
               exp_pos = lp; exp_neg = ln; exp_ok = 1;
            end else begin
               exp_ap_pos[exp_applies] = opos; exp_ap_neg[exp_applies] = oneg;
               exp_applies++;
               exp_pos = opos; exp_neg = oneg; exp_ok = 0;
            end
            return;
         end
         c = ((mx - mn) >> 1) + mn;
         if (r == 0) begin med = c; prev = c; p = c; n = c; end
         else if (r[0]) begin prev = c; p = c; n = med; end
         else begin p = prev; n = c; end
         exp_ap_pos[exp_applies] = p; exp_ap_neg[exp_applies] = n;
         exp_applies++;
         lp = p; ln = n;
      end
      exp_pos = lp; exp_neg = ln; exp_ok = 1;
   endtask

   // tester model: answers every request, latency varies
   initial begin
      int cp, cn, r;
      bit ck;
      forever begin
         @(negedge clk);
         trial_done = 1'b0;
         if (trial_start) begin
            cp = int'(trial_pos); cn = int'(trial_neg); ck = trial_check;
            r = n_applies;
            if (ck) begin
               n_trials++;
               if (cp > max_seen) max_seen = cp;
               if (cn > max_seen) max_seen = cn;
               if (r == 0) begin
                  if (cp != r0_idx || cn != r0_idx) r0_err++;
                  r0_idx++;
               end else if (r < 8) begin
                  if (r[0] && cn != exp_fixed[r]) fix_err++;
                  if (!r[0] && cp != exp_fixed[r]) fix_err++;
               end
            end else begin
               if (n_applies < 8) begin
                  got_ap_pos[n_applies] = cp; got_ap_neg[n_applies] = cn;
               end
               n_applies++;
            end
            lat = (lat + 1) % 3;
            repeat (lat) @(negedge clk);
            @(negedge clk);
            trial_done = 1'b1;
            trial_pass = ck ? pass_fn(cp, cn, r) : 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (train_done) done_hi++;
      end
   end

   task automatic run_case(input string req, input int a, input int b, input int c, input int d,
                           input int h, input int k, input int op, input int on);
      int guard, gp, gn, gk, aerr;
      plo = a; phi = b; nlo = c; nhi = d; hole = h; kill = k;
      ref_run(op, on);
      n_trials = 0; n_applies = 0; max_seen = 0; r0_idx = 0; r0_err = 0; fix_err = 0; done_hi = 0;
      @(negedge clk);
      init_pos = 6'(op); init_neg = 6'(on); train_go = 1'b1;
      @(negedge clk);
      train_go = 1'b0;
      guard = 0;
      while (!train_done && guard < 30000) begin
         @(negedge clk);
         guard++;
      end
      gp = int'(final_pos); gn = int'(final_neg); gk = int'(train_ok);
      @(negedge clk);
      @(negedge clk);
      chk(guard < 30000, req, "finished", guard, 30000);
      chk(gk == exp_ok, req, "status", gk, exp_ok);
      chk(gp == exp_pos, req, "final pos", gp, exp_pos);
      chk(gn == exp_neg, req, "final neg", gn, exp_neg);
      chk(n_trials == exp_trials, "R4", "trial count", n_trials, exp_trials);
      chk(r0_err == 0 && r0_idx == ((exp_trials < 64) ? exp_trials : 64), "R2", "sweep order errors", r0_err, 0);
      chk(fix_err == 0, "R5", "held code errors", fix_err, 0);
      chk(n_applies == exp_applies, "R6", "apply count", n_applies, exp_applies);
      aerr = 0;
      for (int i = 0; i < exp_applies && i < 8; i++)
         if (got_ap_pos[i] != exp_ap_pos[i] || got_ap_neg[i] != exp_ap_neg[i]) aerr++;
      chk(aerr == 0, "R6", "installed code mismatches", aerr, 0);
      chk(max_seen <= 63, "R11", "highest code", max_seen, 63);
      chk(done_hi == 1, "R12", "done pulse cycles", done_hi, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      n_trials = 0; n_applies = 0; lat = 0; kill = 9; hole = -1;
      plo = 0; phi = 0; nlo = 0; nhi = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(train_done == 1'b0, "R1", "done after reset", int'(train_done), 0);
      chk(trial_start == 1'b0, "R1", "start after reset", int'(trial_start), 0);
      chk(n_trials == 0 && n_applies == 0, "R1", "requests before go", n_trials + n_applies, 0);
      run_case("R10", 10, 40, 20, 50, -1, 9, 5, 9);
      run_case("R11", 0, 63, 0, 63, -1, 9, 1, 2);
      run_case("R7", 70, 80, 0, 63, -1, 9, 33, 44);
      run_case("R3", 8, 30, 8, 30, 12, 9, 3, 4);
      run_case("R4", 0, 5, 0, 63, -1, 9, 7, 7);
      run_case("R4", 58, 63, 50, 63, -1, 9, 0, 0);
      run_case("R8", 10, 40, 20, 50, -1, 1, 11, 12);
      run_case("R8", 10, 40, 20, 50, -1, 2, 13, 14);
      run_case("R8", 10, 40, 20, 50, -1, 3, 15, 16);
      run_case("R9", 10, 40, 20, 50, -1, 4, 17, 18);
      run_case("R8", 10, 40, 20, 50, -1, 5, 19, 20);
      run_case("R8", 10, 40, 20, 50, -1, 6, 21, 22);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule